// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block brings a DDR or LPDDR SDRAM from power-on to a usable state. It walks a fixed list of eight packed command words. Each word carries a row address, a bank address and a RAS/CAS/WE command code. The block decodes each word onto the SDRAM command pins and drives NOP between entries, so the memory sees the timing gaps it needs. When the list is done it waits a settling period and then raises `init_done`.

Two static configuration inputs pick the variant. `cfg_lpddr` selects the low-power sequence, which has an extra long stabilisation wait before its second entry. `cfg_bl4` selects a burst length of 4 instead of 2 in the mode register values. The gap, the long wait and the final settling period are all parameters counted in clock cycles. Normal traffic, periodic refresh and the data path belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, the command pins carry NOP (RAS/CAS/WE = 111) and `init_done` is 0.
- R2: A command word is decoded as follows: bits 25:13 go to `sd_addr`, bits 12:11 go to `sd_ba`, and bits 6:4 go to RAS, CAS and WE in that order. The codes are NOP 111, PRECHARGE 010, AUTO REFRESH 001 and LOAD MODE 000. A PRECHARGE always has address bit 10 set (row 0x400).
- R3: With `cfg_lpddr`=0 the entries, in order, are (command/bank/row):
  1. NOP/0/0x000
  2. PRE/0/0x400
  3. LOAD MODE/1/0x001
  4. LOAD MODE/0/MR with DLL reset
  5. PRE/0/0x400
  6. REF/0/0
  7. REF/0/0
  8. LOAD MODE/0/MR with no DLL reset
- R4: With `cfg_lpddr`=1 the entries, in order, are:
  1. NOP/0/0
  2. NOP/0/0
  3. PRE/0/0x400
  4. REF/0/0
  5. REF/0/0
  6. LOAD MODE/0/MR
  7. LOAD MODE/1/0x000
  8. NOP/0/0
- R5: The mode register value is 0x020 (CAS latency 2) plus 0x001 when `cfg_bl4`=0 or 0x002 when `cfg_bl4`=1. The DLL-reset entry adds 0x100, which gives 0x121 or 0x122.
- R6: The first entry appears on the first rising edge after reset is released. Consecutive entries are separated by exactly `GAP_CYCLES` NOP cycles, and each entry lasts one cycle.
- R7: In the LPDDR sequence, exactly `PWRUP_WAIT` NOP cycles separate the first and second entries.
- R8: `sd_cke` stays 0 until the cycle of the first entry and stays 1 from then on.
- R9: After the last entry the block drives `FINAL_WAIT` NOP cycles with `init_done`=0. `init_done` goes to 1 in the next cycle and stays there until reset, while the pins keep NOP.
- R10: `sd_cs_n` is 0 in every cycle.
- R11: Asserting reset during the sequence returns the block to its R1 state. After release, the sequence restarts from its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lpddr | input | 1 | 1 selects the low-power sequence |
| cfg_bl4 | input | 1 | 1 selects burst length 4, 0 selects burst length 2 |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row address strobe |
| sd_cas_n | output | 1 | Column address strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/mode address |
| init_done | output | 1 | High once initialization is complete |

## Verification
The checker assumes that `cfg_lpddr` and `cfg_bl4` do not change while reset is released. It also assumes every timing parameter is at least 1, so each command is followed by at least one NOP cycle. The bench meets both conditions: it changes the configuration only while reset is held, and it uses small positive values for the gap, long-wait and settling parameters. It runs all four configuration combinations and one reset taken in the middle of a sequence.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int GAP_CYCLES = 4,
  parameter int PWRUP_WAIT = 25000,
  parameter int FINAL_WAIT = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_lpddr,
  input  logic        cfg_bl4,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [12:0] sd_addr,
  output logic        init_done
);
  localparam int NUM_ENT = 8;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int MAX_W   = (PWRUP_WAIT > FINAL_WAIT) ?
                           ((PWRUP_WAIT > GAP_CYCLES) ? PWRUP_WAIT : GAP_CYCLES) :
                           ((FINAL_WAIT > GAP_CYCLES) ? FINAL_WAIT : GAP_CYCLES);
  localparam int CNT_W   = $clog2(MAX_W + 1);

  localparam logic [2:0]  C_NOP = 3'b111, C_PRE = 3'b010, C_REF = 3'b001, C_LMR = 3'b000;
  localparam logic [12:0] ROW_A10 = 13'h400, MR_CL2 = 13'h020, MR_DLLRST = 13'h100;

  typedef enum logic [1:0] {PH_ISSUE, PH_GAP, PH_FINAL, PH_DONE} phase_t;

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      cur_word;
  logic [CNT_W-1:0] next_wait;

  function automatic logic [31:0] pack(input logic [12:0] row, input logic [1:0] ba,
                                       input logic [2:0] cmd);
    return {6'd0, row, ba, 4'd0, cmd, 4'd0};
  endfunction

  function automatic logic [12:0] row_of(input logic [31:0] w);
    return w[25:13];
  endfunction

  function automatic logic [1:0] ba_of(input logic [31:0] w);
    return w[12:11];
  endfunction

  function automatic logic [2:0] cmd_of(input logic [31:0] w);
    return w[6:4];
  endfunction

  function automatic logic [31:0] seq_word(input logic [IDX_W-1:0] i, input logic lp,
                                           input logic bl4);
    logic [12:0] mr;
    mr = MR_CL2 | (bl4 ? 13'h002 : 13'h001);
    if (!lp) begin
      case (i)
        3'd0:    return pack(13'h000, 2'd0, C_NOP);
        3'd1:    return pack(ROW_A10, 2'd0, C_PRE);
        3'd2:    return pack(13'h001, 2'd1, C_LMR);
        3'd3:    return pack(mr | MR_DLLRST, 2'd0, C_LMR);
        3'd4:    return pack(ROW_A10, 2'd0, C_PRE);
        3'd5:    return pack(13'h000, 2'd0, C_REF);
        3'd6:    return pack(13'h000, 2'd0, C_REF);
        default: return pack(mr, 2'd0, C_LMR);
      endcase
    end else begin
      case (i)
        3'd0:    return pack(13'h000, 2'd0, C_NOP);
        3'd1:    return pack(13'h000, 2'd0, C_NOP);
        3'd2:    return pack(ROW_A10, 2'd0, C_PRE);
        3'd3:    return pack(13'h000, 2'd0, C_REF);
        3'd4:    return pack(13'h000, 2'd0, C_REF);
        3'd5:    return pack(mr, 2'd0, C_LMR);
        3'd6:    return pack(13'h000, 2'd1, C_LMR);
        default: return pack(13'h000, 2'd0, C_NOP);
      endcase
    end
  endfunction

  assign cur_word  = seq_word(idx, cfg_lpddr, cfg_bl4);
  assign next_wait = (idx == IDX_W'(NUM_ENT - 1)) ? CNT_W'(FINAL_WAIT) :
                     (cfg_lpddr && idx == '0)     ? CNT_W'(PWRUP_WAIT) :
                                                    CNT_W'(GAP_CYCLES);
  assign sd_cs_n = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ISSUE;
      idx       <= '0;
      cnt       <= '0;
      sd_cke    <= 1'b0;
      {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      init_done <= 1'b0;
    end else begin
      {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
      case (phase)
        PH_ISSUE: begin
          sd_cke  <= 1'b1;
          {sd_ras_n, sd_cas_n, sd_we_n} <= cmd_of(cur_word);
          sd_ba   <= ba_of(cur_word);
          sd_addr <= row_of(cur_word);
          cnt     <= next_wait;
          phase   <= (idx == IDX_W'(NUM_ENT - 1)) ? PH_FINAL : PH_GAP;
        end
        PH_GAP: begin
          if (cnt == CNT_W'(1)) begin
            idx   <= idx + 1'b1;
            phase <= PH_ISSUE;
          end
          cnt <= cnt - 1'b1;
        end
        PH_FINAL: begin
          if (cnt == CNT_W'(1)) phase <= PH_DONE;
          cnt <= cnt - 1'b1;
        end
        default: init_done <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sd_cke,
  input logic        sd_cs_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic [12:0] sd_addr,
  input logic        init_done
);
  logic [2:0] cmd;
  assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  AST_CS_ALWAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sd_cs_n); // R10
  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sd_cke |=> sd_cke); // R8
  AST_CKE_LOW_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n) !sd_cke |-> cmd == 3'b111); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> cmd == 3'b111); // R9
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n) cmd != 3'b111 |=> cmd == 3'b111); // R6
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) cmd == 3'b010 |-> sd_addr[10]); // R2
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int GAP = 3, PWR = 20, FIN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lpddr = 1'b0, cfg_bl4 = 1'b0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;
  int n_chk = 0, n_err = 0;

  logic [2:0]  e_cmd [8];
  logic [1:0]  e_ba  [8];
  logic [12:0] e_row [8];

  always #4 clk = ~clk;

  sdram_init_seq #(.GAP_CYCLES(GAP), .PWRUP_WAIT(PWR), .FINAL_WAIT(FIN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lpddr(cfg_lpddr), .cfg_bl4(cfg_bl4),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pins(input string tag, input logic cke, input logic [2:0] cmd,
                      input logic [1:0] ba, input logic [12:0] a, input logic done);
    chk(tag, "cke", sd_cke, cke);
    chk(tag, "cmd", {sd_ras_n, sd_cas_n, sd_we_n}, cmd);
    if (cmd != 3'b111) begin
      chk(tag, "bank", sd_ba, ba);
      chk(tag, "addr", sd_addr, a);
    end
    chk("R10", "cs_n", sd_cs_n, 1'b0);
    chk(tag, "done", init_done, done);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_table(input logic lp, input logic bl4);
    logic [12:0] mr;
    mr = bl4 ? 13'h022 : 13'h021;
    if (!lp) begin
      e_cmd = '{3'd7, 3'd2, 3'd0, 3'd0, 3'd2, 3'd1, 3'd1, 3'd0};
      e_ba  = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
      e_row = '{13'h0, 13'h400, 13'h001, mr | 13'h100, 13'h400, 13'h0, 13'h0, mr};
    end else begin
      e_cmd = '{3'd7, 3'd7, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd7};
      e_ba  = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0};
      e_row = '{13'h0, 13'h0, 13'h400, 13'h0, 13'h0, mr, 13'h0, 13'h0};
    end
  endtask

  task automatic apply_reset(input logic lp, input logic bl4);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_lpddr = lp;
    cfg_bl4 = bl4;
    #1;
    pins("R1", 1'b0, 3'b111, 2'd0, 13'd0, 1'b0);
    step();
    pins("R8", 1'b0, 3'b111, 2'd0, 13'd0, 1'b0);
    rst_n = 1'b1;
  endtask

  // one configuration from reset through done
  task automatic run_cfg(input logic lp, input logic bl4);
    string etag;
    apply_reset(lp, bl4);
    load_table(lp, bl4);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin
        for (int g = 0; g < ((lp && k == 1) ? PWR : GAP); g++) begin
          step();
          pins((lp && k == 1) ? "R7" : "R6", 1'b1, 3'b111, 2'd0, 13'd0, 1'b0);
        end
      end
      step();
      etag = (e_cmd[k] == 3'd0) ? "R5" : (lp ? "R4" : "R3");
      pins(etag, 1'b1, e_cmd[k], e_ba[k], e_row[k], 1'b0);
      if (e_cmd[k] == 3'b010) chk("R2", "a10", sd_addr[10], 1'b1);
    end
    for (int g = 0; g < FIN; g++) begin
      step();
      pins("R9", 1'b1, 3'b111, 2'd0, 13'd0, 1'b0);
    end
    for (int g = 0; g < 4; g++) begin
      step();
      pins("R9", 1'b1, 3'b111, 2'd0, 13'd0, 1'b1);
    end
  endtask

  // reset in the middle of the DDR sequence
  task automatic mid_reset();
    apply_reset(1'b0, 1'b1);
    step();
    for (int k = 1; k < 4; k++) repeat (GAP + 1) step();
    pins("R11", 1'b1, 3'b000, 2'd0, 13'h122, 1'b0);
    step();
    rst_n = 1'b0;
    #1;
    pins("R11", 1'b0, 3'b111, 2'd0, 13'd0, 1'b0);
    step();
    rst_n = 1'b1;
    step();
    pins("R11", 1'b1, 3'b111, 2'd0, 13'd0, 1'b0);
    repeat (GAP) step();
    step();
    pins("R11", 1'b1, 3'b010, 2'd0, 13'h400, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule